// File: doc/BRIEF.md
# Line-Synchronised Slot Arbiter for a Shared Byte RAM

This block shares one byte-wide synchronous RAM among four requesters: an acquisition writer that stores incoming teletext bytes, a display reader, a block-transfer engine that moves bytes between a 40-byte buffer and the RAM, and the host CPU. Access is split in time. A fixed frame of eight slots runs back to back. Each slot moves at most one byte, and it belongs to one requester class. Four of the eight slots are real-time (RT) slots. The other four are split evenly between the CPU and the block-transfer engine.

A horizontal sync pulse ends the frame early. The slot in progress still finishes, and the next slot is the first slot of the frame. A line tracker counts lines from vertical sync. On lines 1 through 24 the RT slots serve acquisition. On every later line they serve the display. The requester's own port supplies the address, the write data and the direction. Each requester gets a one-clock done strobe when its byte has moved. The CPU sees a wait signal until its request is served.

The slot sequencer FSM has eight states in frame order: `SL_RT0`, `SL_CPU0`, `SL_RT1`, `SL_MBT0`, `SL_RT2`, `SL_CPU1`, `SL_RT3`, `SL_MBT1`. In the last clock of a slot it takes the ADVANCE transition to the next state in that order, wrapping from `SL_MBT1` back to `SL_RT0`. If a sync has been seen, it takes the RESTART transition to `SL_RT0` instead. In every other clock it HOLDs. The field FSM has two states, `FLD_ACQ` and `FLD_DISP`. At each line start it takes TO_ACQ when vertical sync was seen or when the new line number is 24 or less. Otherwise it takes TO_DISP.

Top module: `line_slot_arbiter`

## Requirements
- R1: The RAM port has a 13-bit byte address and 8-bit data, and it behaves as a synchronous RAM. An access is issued (`mem_en` high) only in the first clock of a slot. The requester's done strobe rises in the next clock. For a read, `rd_byte` carries the RAM byte during that strobe.
- R2: A slot moves at most one byte, for one requester. Each done strobe is high for exactly one clock per transfer, and no two done strobes are high in the same clock.
- R3: Without syncs, slots last `SLOT_CLKS` clocks (default 2) and repeat in the order RT, CPU, RT, MBT, RT, CPU, RT, MBT. The first done of the eighth slot comes 14 clocks after the first done of the first slot.
- R4: A horizontal sync that arrives during a slot lets that slot complete. The next slot is the first RT slot of a new frame.
- R5: An acquisition slot writes `acq_wdata` to `acq_addr`. A display slot only reads, from `disp_addr`, and the byte appears on `rd_byte` while `disp_done` is high.
- R6: Block-transfer slots and CPU slots move one byte in the direction their `*_we` input selects (1 = write, 0 = read), at their own address.
- R7: Vertical sync sets the line number to 1, and each horizontal sync adds one. RT slots serve only acquisition on lines 1 to 24 and only display on later lines. The new choice applies from the first slot of the new line.
- R8: `cpu_wait` is high whenever `cpu_req` is high and the CPU transfer is not completing. It is low in the clock of `cpu_done`.
- R9: If the slot's requester has no request at the slot's first clock, the slot leaves the RAM idle: no enable, no write and no done strobe.
- R10: After reset the sequencer is in the first clock of `SL_RT0`, the field is acquisition (line 1), and all enables and strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync pulse |
| vsync | input | 1 | Vertical sync pulse |
| acq_req | input | 1 | Acquisition byte pending |
| acq_addr | input | 13 | Acquisition write address |
| acq_wdata | input | 8 | Acquisition write byte |
| acq_done | output | 1 | Acquisition byte written |
| disp_req | input | 1 | Display byte wanted |
| disp_addr | input | 13 | Display read address |
| disp_done | output | 1 | Display byte valid on rd_byte |
| mbt_req | input | 1 | Block-transfer byte pending |
| mbt_we | input | 1 | Block-transfer direction, 1 = write |
| mbt_addr | input | 13 | Block-transfer address |
| mbt_wdata | input | 8 | Block-transfer write byte |
| mbt_done | output | 1 | Block-transfer byte moved |
| cpu_req | input | 1 | CPU access pending |
| cpu_we | input | 1 | CPU direction, 1 = write |
| cpu_addr | input | 13 | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_done | output | 1 | CPU byte moved |
| cpu_wait | output | 1 | CPU must hold its request |
| rd_byte | output | 8 | Read byte returned to the requester |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 13 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one clock after the address |

## Verification
The bench puts a horizontal sync in the first clock of an RT slot that follows a CPU slot. A sequencer that drops the slot in progress would lose that slot's acquisition strobe. A sequencer that ignores the sync would serve the block-transfer slot next, where two acquisition strobes and then a CPU strobe are expected. The field boundary is probed on lines 24 and 25 and again after vertical sync. An off-by-one line count would give the display a slot on line 24, or hold acquisition on line 25. Other checks cover the CPU wait timing when a request arrives just before two hardware clocks, display reads that must not write, and idle slots that must leave the RAM untouched.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Slot sequencer states, in frame order
    typedef enum logic [2:0] {
        SL_RT0  = 3'd0,
        SL_CPU0 = 3'd1,
        SL_RT1  = 3'd2,
        SL_MBT0 = 3'd3,
        SL_RT2  = 3'd4,
        SL_CPU1 = 3'd5,
        SL_RT3  = 3'd6,
        SL_MBT1 = 3'd7
    } slot_e;

    // Requester class that owns a slot
    typedef enum logic [1:0] {
        OWN_RT  = 2'd0,
        OWN_CPU = 2'd1,
        OWN_MBT = 2'd2
    } owner_e;

    // Concrete requester routed to the RAM
    typedef enum logic [1:0] {
        SRC_ACQ  = 2'd0,
        SRC_DISP = 2'd1,
        SRC_MBT  = 2'd2,
        SRC_CPU  = 2'd3
    } src_e;

    // Field state: who the real-time slots serve on this line
    typedef enum logic {
        FLD_ACQ  = 1'b0,
        FLD_DISP = 1'b1
    } field_e;

    function automatic owner_e slot_owner(input slot_e s);
        owner_e o;
        unique case (s)
            SL_CPU0, SL_CPU1: o = OWN_CPU;
            SL_MBT0, SL_MBT1: o = OWN_MBT;
            default:          o = OWN_RT;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lsa_line_tracker.sv
module lsa_line_tracker
    import lsa_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int ACQ_LAST = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    input  logic line_start,
    output logic sync_seen,
    output logic rt_acq
);

    localparam logic [LINE_W-1:0] LINE_FIRST = LINE_W'(1);
    localparam logic [LINE_W-1:0] LINE_MAX   = '1;
    localparam logic [LINE_W-1:0] ACQ_END    = LINE_W'(ACQ_LAST);

    logic              hpend_q;
    logic              vpend_q;
    logic              vs_seen;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_d;
    field_e            field_q;
    field_e            field_d;

    // A sync pulse is kept pending until the sequencer reaches a slot end
    always_comb begin
        sync_seen = hpend_q | vpend_q | hsync | vsync;
        vs_seen   = vpend_q | vsync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpend_q <= 1'b0;
            vpend_q <= 1'b0;
        end else if (line_start) begin
            hpend_q <= 1'b0;
            vpend_q <= 1'b0;
        end else begin
            hpend_q <= hpend_q | hsync;
            vpend_q <= vpend_q | vsync;
        end
    end

    // Next line number and field transition (TO_ACQ / TO_DISP)
    always_comb begin
        line_d  = line_q;
        field_d = field_q;
        if (line_start) begin
            if (vs_seen) begin
                line_d = LINE_FIRST;
            end else if (line_q != LINE_MAX) begin
                line_d = line_q + 1'b1;
            end
            unique case (field_q)
                FLD_ACQ:  field_d = (line_d > ACQ_END) ? FLD_DISP : FLD_ACQ;
                FLD_DISP: field_d = (line_d > ACQ_END) ? FLD_DISP : FLD_ACQ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= LINE_FIRST;
            field_q <= FLD_ACQ;
        end else begin
            line_q  <= line_d;
            field_q <= field_d;
        end
    end

    always_comb rt_acq = (field_q == FLD_ACQ);

    AST_VSYNC_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && vs_seen) |=> (line_q == LINE_FIRST && field_q == FLD_ACQ)); // R7
    AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == FLD_ACQ) |-> (line_q <= ACQ_END)); // R7
    AST_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(field_q)); // R7

endmodule

// File: rtl/lsa_slot_fsm.sv
module lsa_slot_fsm
    import lsa_pkg::*;
#(
    parameter int SLOT_CLKS = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_seen,
    output slot_e slot,
    output logic  slot_first,
    output logic  slot_last,
    output logic  line_start
);

    localparam int              PH_W    = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CLKS - 1);

    slot_e           slot_q;
    slot_e           slot_d;
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_d;
    logic            at_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= SL_RT0;
            phase_q <= '0;
        end else begin
            slot_q  <= slot_d;
            phase_q <= phase_d;
        end
    end

    // Transitions: HOLD inside a slot, RESTART on sync, ADVANCE otherwise
    always_comb begin
        at_end  = (phase_q == PH_LAST);
        slot_d  = slot_q;
        phase_d = phase_q + 1'b1;
        if (at_end) begin
            phase_d = '0;
            if (sync_seen) begin
                slot_d = SL_RT0;
            end else begin
                unique case (slot_q)
                    SL_RT0:  slot_d = SL_CPU0;
                    SL_CPU0: slot_d = SL_RT1;
                    SL_RT1:  slot_d = SL_MBT0;
                    SL_MBT0: slot_d = SL_RT2;
                    SL_RT2:  slot_d = SL_CPU1;
                    SL_CPU1: slot_d = SL_RT3;
                    SL_RT3:  slot_d = SL_MBT1;
                    SL_MBT1: slot_d = SL_RT0;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        slot       = slot_q;
        slot_first = (phase_q == '0);
        slot_last  = at_end;
        line_start = at_end & sync_seen;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_last |=> $stable(slot_q)); // R3
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_last && !sync_seen && slot_q == SL_MBT1) |=> (slot_q == SL_RT0)); // R3
    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (slot_q == SL_RT0 && slot_first)); // R4

endmodule

// File: rtl/lsa_port_mux.sv
module lsa_port_mux
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic              slot_first,
    input  logic              rt_acq,
    input  logic              acq_req,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [DATA_W-1:0] acq_wdata,
    input  logic              disp_req,
    input  logic [ADDR_W-1:0] disp_addr,
    input  logic              mbt_req,
    input  logic              mbt_we,
    input  logic [ADDR_W-1:0] mbt_addr,
    input  logic [DATA_W-1:0] mbt_wdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic              acq_done,
    output logic              disp_done,
    output logic              mbt_done,
    output logic              cpu_done,
    output logic              cpu_wait
);

    src_e              src;
    src_e              src_q;
    logic              served_q;
    logic              sel_req;
    logic              sel_we;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              issue;

    // Which requester owns the current slot
    always_comb begin
        unique case (slot_owner(slot))
            OWN_CPU: src = SRC_CPU;
            OWN_MBT: src = SRC_MBT;
            default: src = rt_acq ? SRC_ACQ : SRC_DISP;
        endcase
    end

    // Route that requester's address, data and direction
    always_comb begin
        unique case (src)
            SRC_ACQ: begin
                sel_req   = acq_req;
                sel_we    = 1'b1;
                sel_addr  = acq_addr;
                sel_wdata = acq_wdata;
            end
            SRC_DISP: begin
                sel_req   = disp_req;
                sel_we    = 1'b0;
                sel_addr  = disp_addr;
                sel_wdata = '0;
            end
            SRC_MBT: begin
                sel_req   = mbt_req;
                sel_we    = mbt_we;
                sel_addr  = mbt_addr;
                sel_wdata = mbt_wdata;
            end
            SRC_CPU: begin
                sel_req   = cpu_req;
                sel_we    = cpu_we;
                sel_addr  = cpu_addr;
                sel_wdata = cpu_wdata;
            end
        endcase
    end

    always_comb begin
        issue     = slot_first & sel_req;
        mem_en    = issue;
        mem_we    = issue & sel_we;
        mem_addr  = sel_addr;
        mem_wdata = sel_wdata;
    end

    // Completion is one clock after issue, when read data is valid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            served_q <= 1'b0;
            src_q    <= SRC_ACQ;
        end else begin
            served_q <= issue;
            src_q    <= src;
        end
    end

    always_comb begin
        acq_done  = served_q && (src_q == SRC_ACQ);
        disp_done = served_q && (src_q == SRC_DISP);
        mbt_done  = served_q && (src_q == SRC_MBT);
        cpu_done  = served_q && (src_q == SRC_CPU);
        rd_byte   = mem_rdata;
        cpu_wait  = cpu_req & ~cpu_done;
    end

    AST_EN_FIRST_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> slot_first); // R1
    AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_done || disp_done || mbt_done || cpu_done) |-> $past(mem_en)); // R1
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acq_done, disp_done, mbt_done, cpu_done})); // R2
    AST_ACQ_WROTE: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> $past(mem_we)); // R5
    AST_DISP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_done |-> !$past(mem_we)); // R5
    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R9
    AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_wait) |-> cpu_done); // R8

endmodule

// File: rtl/line_slot_arbiter.sv
module line_slot_arbiter
    import lsa_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int SLOT_CLKS = 2,
    parameter int LINE_W    = 10,
    parameter int ACQ_LAST  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              acq_req,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [DATA_W-1:0] acq_wdata,
    output logic              acq_done,
    input  logic              disp_req,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic              disp_done,
    input  logic              mbt_req,
    input  logic              mbt_we,
    input  logic [ADDR_W-1:0] mbt_addr,
    input  logic [DATA_W-1:0] mbt_wdata,
    output logic              mbt_done,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic              cpu_wait,
    output logic [DATA_W-1:0] rd_byte,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    slot_e slot;
    logic  slot_first;
    logic  slot_last;
    logic  line_start;
    logic  sync_seen;
    logic  rt_acq;

    lsa_line_tracker #(
        .LINE_W   (LINE_W),
        .ACQ_LAST (ACQ_LAST)
    ) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .vsync      (vsync),
        .line_start (line_start),
        .sync_seen  (sync_seen),
        .rt_acq     (rt_acq)
    );

    lsa_slot_fsm #(
        .SLOT_CLKS (SLOT_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_seen  (sync_seen),
        .slot       (slot),
        .slot_first (slot_first),
        .slot_last  (slot_last),
        .line_start (line_start)
    );

    lsa_port_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .slot_first (slot_first),
        .rt_acq     (rt_acq),
        .acq_req    (acq_req),
        .acq_addr   (acq_addr),
        .acq_wdata  (acq_wdata),
        .disp_req   (disp_req),
        .disp_addr  (disp_addr),
        .mbt_req    (mbt_req),
        .mbt_we     (mbt_we),
        .mbt_addr   (mbt_addr),
        .mbt_wdata  (mbt_wdata),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .rd_byte    (rd_byte),
        .acq_done   (acq_done),
        .disp_done  (disp_done),
        .mbt_done   (mbt_done),
        .cpu_done   (cpu_done),
        .cpu_wait   (cpu_wait)
    );

    AST_SLOT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> slot_last); // R4

endmodule

// File: tb/line_slot_arbiter_test.sv
module line_slot_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        acq_req = 1'b0;
    logic [12:0] acq_addr = '0;
    logic [7:0]  acq_wdata = '0;
    logic        acq_done;
    logic        disp_req = 1'b0;
    logic [12:0] disp_addr = '0;
    logic        disp_done;
    logic        mbt_req = 1'b0;
    logic        mbt_we = 1'b0;
    logic [12:0] mbt_addr = '0;
    logic [7:0]  mbt_wdata = '0;
    logic        mbt_done;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_done;
    logic        cpu_wait;
    logic [7:0]  rd_byte;
    logic        mem_en;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int errors = 0;
    int cap_en;
    int cap_we;
    int cap_en_k;
    int cap_addr;
    int cap_rd;

    logic [7:0] ram [0:1023];

    always #4 clk = ~clk;

    // Synchronous RAM model: read data one clock after the address
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[9:0]];
        end
    end

    line_slot_arbiter uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .acq_req(acq_req), .acq_addr(acq_addr), .acq_wdata(acq_wdata), .acq_done(acq_done),
        .disp_req(disp_req), .disp_addr(disp_addr), .disp_done(disp_done),
        .mbt_req(mbt_req), .mbt_we(mbt_we), .mbt_addr(mbt_addr), .mbt_wdata(mbt_wdata),
        .mbt_done(mbt_done),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_wait(cpu_wait), .rd_byte(rd_byte),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] dones();
        return {cpu_done, mbt_done, disp_done, acq_done};
    endfunction

    function automatic int done_code(input logic [3:0] d);
        if (d[0]) return 0;
        if (d[1]) return 1;
        if (d[2]) return 2;
        return 3;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_pulse(input bit vert);
        @(negedge clk);
        if (vert) vsync = 1'b1;
        else      hsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        hsync = 1'b0;
        tick(3);
    endtask

    // Wait for a done strobe (0 acq, 1 disp, 2 mbt, 3 cpu), recording RAM activity
    task automatic serve(input int which, output int n);
        logic [3:0] d;
        n = 0; cap_en = 0; cap_we = 0; cap_en_k = -1; cap_addr = -1;
        forever begin
            @(negedge clk);
            n++;
            if (mem_en) begin
                cap_en++;
                cap_en_k = n;
                cap_addr = int'(mem_addr);
                if (mem_we) cap_we++;
            end
            d = dones();
            if (d[which]) break;
            if (n > 100) break;
        end
        cap_rd = int'(rd_byte);
        chk("serve timeout", int'(n <= 100), 1);
    endtask

    task automatic count_rt(output int na, output int nd);
        na = 0; nd = 0;
        acq_req = 1'b1; acq_addr = 13'h03FF; acq_wdata = 8'hEE;
        disp_req = 1'b1; disp_addr = 13'h0001;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (acq_done) na++;
            if (disp_done) nd++;
        end
        acq_req = 1'b0;
        disp_req = 1'b0;
        tick(2);
    endtask

    task automatic test_reset();
        #1;
        chk("R10 mem_en after reset", int'(mem_en), 0);
        chk("R10 dones after reset", int'(dones()), 0);
        chk("R10 cpu_wait after reset", int'(cpu_wait), 0);
    endtask

    task automatic test_order();
        int exp_o [8] = '{0, 3, 0, 2, 0, 3, 0, 2};
        int got [8];
        int n = 0;
        int first = 0;
        int last = 0;
        logic [3:0] d;
        acq_req = 1'b1; acq_addr = 13'h0010; acq_wdata = 8'h11;
        mbt_req = 1'b1; mbt_we = 1'b0; mbt_addr = 13'h0020;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 13'h0030;
        for (int k = 1; k <= 40 && n < 8; k++) begin
            @(negedge clk);
            d = dones();
            if (d != 4'b0) begin
                chk("R2 single done strobe", $countones(d), 1);
                if (n == 0) first = k;
                last = k;
                got[n] = done_code(d);
                n++;
            end
        end
        acq_req = 1'b0; mbt_req = 1'b0; cpu_req = 1'b0;
        chk("R10 first slot is acquisition", got[0], 0);
        for (int i = 0; i < 8; i++) chk($sformatf("R3 slot %0d owner", i), got[i], exp_o[i]);
        chk("R3 frame period", last - first, 14);
        tick(4);
    endtask

    task automatic test_acq_write();
        int n;
        sync_pulse(1'b1);
        acq_addr = 13'h1234; acq_wdata = 8'h5A; acq_req = 1'b1;
        serve(0, n);
        acq_req = 1'b0;
        chk("R5 acquisition address", cap_addr, 'h1234);
        chk("R2 one write for one request", cap_we, 1);
        chk("R1 done one clock after enable", n - cap_en_k, 1);
        chk("R5 acquisition byte stored", int'(ram[10'h234]), 'h5A);
        tick(4);
    endtask

    task automatic test_modes();
        int na;
        int nd;
        sync_pulse(1'b1);
        repeat (23) sync_pulse(1'b0);
        count_rt(na, nd);
        chk("R7 line 24 serves acquisition", int'(na > 0), 1);
        chk("R7 line 24 gives display nothing", nd, 0);
        sync_pulse(1'b0);
        count_rt(na, nd);
        chk("R7 line 25 serves display", int'(nd > 0), 1);
        chk("R7 line 25 gives acquisition nothing", na, 0);
        sync_pulse(1'b1);
        count_rt(na, nd);
        chk("R7 vsync returns to acquisition", int'(na > 0), 1);
        chk("R7 vsync stops display", nd, 0);
    endtask

    task automatic test_disp_read();
        int n;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 13'h10AB; cpu_wdata = 8'hC3;
        serve(3, n);
        cpu_req = 1'b0;
        chk("R6 cpu write strobe", cap_we, 1);
        sync_pulse(1'b1);
        repeat (24) sync_pulse(1'b0);
        disp_req = 1'b1; disp_addr = 13'h10AB;
        serve(1, n);
        disp_req = 1'b0;
        chk("R5 display read data", cap_rd, 'hC3);
        chk("R5 display never writes", cap_we, 0);
        chk("R5 display address", cap_addr, 'h10AB);
        tick(4);
    endtask

    task automatic test_mbt_cpu();
        int n;
        mbt_req = 1'b1; mbt_we = 1'b1; mbt_addr = 13'h0555; mbt_wdata = 8'h77;
        serve(2, n);
        mbt_req = 1'b0;
        chk("R6 block write strobe", cap_we, 1);
        chk("R6 block write address", cap_addr, 'h0555);
        tick(2);
        mbt_req = 1'b1; mbt_we = 1'b0;
        serve(2, n);
        mbt_req = 1'b0;
        chk("R6 block read data", cap_rd, 'h77);
        chk("R6 block read no write", cap_we, 0);
        tick(2);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 13'h1F00; cpu_wdata = 8'h99;
        serve(3, n);
        cpu_req = 1'b0;
        chk("R6 cpu write address", cap_addr, 'h1F00);
        tick(2);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 13'h0555;
        serve(3, n);
        cpu_req = 1'b0;
        chk("R6 cpu reads block-written byte", cap_rd, 'h77);
        tick(4);
    endtask

    task automatic test_cpu_wait();
        int n;
        int waits = 0;
        mbt_req = 1'b1; mbt_we = 1'b0; mbt_addr = 13'h0555;
        serve(2, n);
        mbt_req = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 13'h1F00;
        #1;
        chk("R8 wait rises with request", int'(cpu_wait), 1);
        n = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            n = k;
            if (cpu_done) begin
                chk("R8 wait low at done", int'(cpu_wait), 0);
                chk("R8 cpu read data", int'(rd_byte), 'h99);
                break;
            end
            if (cpu_wait) waits++;
        end
        cpu_req = 1'b0;
        chk("R8 clocks until cpu slot", n, 4);
        chk("R8 wait held through hardware slot", waits, 3);
        tick(4);
    endtask

    task automatic test_hsync_mid();
        int n;
        int exp_s [3] = '{0, 0, 3};
        int seq [3];
        int cnt = 0;
        logic [3:0] d;
        sync_pulse(1'b1);
        acq_req = 1'b1; acq_addr = 13'h03FE; acq_wdata = 8'h42;
        mbt_req = 1'b1; mbt_we = 1'b0; mbt_addr = 13'h0555;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 13'h1F00;
        serve(3, n);
        for (int k = 1; k <= 20 && cnt < 3; k++) begin
            @(negedge clk);
            d = dones();
            if (d != 4'b0) begin
                seq[cnt] = done_code(d);
                cnt++;
            end
            hsync = (k == 1);
        end
        hsync = 1'b0;
        acq_req = 1'b0; mbt_req = 1'b0; cpu_req = 1'b0;
        chk("R4 slot in progress completes", seq[0], exp_s[0]);
        chk("R4 restart at first RT slot", seq[1], exp_s[1]);
        chk("R4 CPU slot follows restart", seq[2], exp_s[2]);
        tick(4);
    endtask

    task automatic test_idle();
        int en_n = 0;
        int we_n = 0;
        int dn_n = 0;
        sync_pulse(1'b1);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (mem_en) en_n++;
            if (mem_we) we_n++;
            if (dones() != 4'b0) dn_n++;
        end
        chk("R9 idle slots no enable", en_n, 0);
        chk("R9 idle slots no write", we_n, 0);
        chk("R9 idle slots no done", dn_n, 0);
        chk("R9 stored byte untouched", int'(ram[10'h234]), 'h5A);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        test_reset();
        test_order();
        test_acq_write();
        test_modes();
        test_disp_read();
        test_mbt_cpu();
        test_cpu_wait();
        test_hsync_mid();
        test_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule